// File: doc/BRIEF.md
# Vertical Frame Shift Phase Sequencer

This block makes the vertical transport clocks of a frame-transfer CCD. There are two groups of four phase clocks. The first group drives the light-sensitive image area. The second group drives the shielded storage area. All timing counts come from a pixel-rate enable (`tick`), so one sequencer step lasts one pixel period.

A frame strobe starts a frame shift. The image group and the storage group then run together for a fixed number of transfer periods, which moves every line from the image area into storage. A line strobe starts a single transfer period on the storage group only. The image group stays at rest. This is used in line blanking to drop one stored line into the horizontal register.

Each transfer period is a fixed number of ticks. Each phase is high for a fixed part of the period, and successive phases are spaced evenly, so neighbouring phases are high at the same time. After the last tick of a run, the block gives a one-cycle completion pulse and goes back to rest.

Top module: `ftx_vshift_seq`

## Requirements
- R1: A transfer period lasts 48 ticks. In each period every phase is high for 30 ticks and low for 18 ticks.
- R2: Bit k of a phase bus (k = 0..3) is high when ((p - 12k) mod 48) < 30. Here p is the tick position within the period, counted from 0. So each phase rises 12 ticks after the phase one bit below it, and a phase bus is never all low.
- R3: In a frame shift, the image and storage buses are identical in every cycle. The shift lasts FRAME_LINES periods.
- R4: In a line transfer, the storage bus runs exactly one period. The image bus holds its rest level throughout.
- R5: While idle, including right after reset, both buses hold the rest level. The rest level is the waveform at p = 0, which is 4'b1101 (bit 1 low).
- R6: Positions advance only on cycles with `tick` high. An output reflects the position one clock after the position register.
- R7: `done` is high for exactly one cycle, on the clock after the final tick of a run. `busy` falls in that same cycle, and a new strobe can be accepted from that cycle on.
- R8: A start strobe of either kind is ignored while `busy` is high. The waveform and the run length stay unchanged.
- R9: If both strobes are high in the same idle cycle, the frame shift is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Pixel-rate step enable |
| start_frame | input | 1 | Starts a full frame shift when idle |
| start_line | input | 1 | Starts a one-line storage transfer when idle |
| img_ph | output | 4 | Image-area phase clocks, bit 0 first phase |
| stor_ph | output | 4 | Storage-area phase clocks, bit 0 first phase |
| busy | output | 1 | A shift or line transfer is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one run and the acceptance of the next strobe. The bench raises a line strobe in the very cycle that `done` is high. It then checks that the new run starts at once and follows the full one-period storage waveform, with no lost or extra cycle. A second overlap is both strobes arriving together. The bench judges this by whether the image bus moves.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_FRAME = 2'd1,
    MODE_LINE  = 2'd2
  } ftx_mode_e;
endpackage

// File: rtl/ftx_phase_gen.sv
// Maps a position inside one transfer period to the level of every phase.
module ftx_phase_gen #(
  parameter int PERIOD = 48,
  parameter int HIGH   = 30,
  parameter int PHASES = 4,
  parameter int PW     = $clog2(PERIOD)
) (
  input  logic [PW-1:0]     pos,
  output logic [PHASES-1:0] lvl
);
  localparam int PW1  = PW + 1;
  localparam int STEP = PERIOD / PHASES;
  localparam logic [PW:0] PER_W  = PW1'(PERIOD);
  localparam logic [PW:0] HIGH_W = PW1'(HIGH);

  for (genvar k = 0; k < PHASES; k++) begin : g_ph
    localparam logic [PW:0] ADD = PW1'(PERIOD - k * STEP);
    logic [PW:0] sum;
    logic [PW:0] rel;
    always_comb begin
      sum = {1'b0, pos} + ADD;
      rel = (sum >= PER_W) ? (sum - PER_W) : sum;
      lvl[k] = (rel < HIGH_W);
    end
  end
endmodule

// File: rtl/ftx_tick_counter.sv
// Position-in-period and period counters, advanced on pixel ticks.
module ftx_tick_counter #(
  parameter int PERIOD = 48,
  parameter int LINES  = 1048,
  parameter int PW     = $clog2(PERIOD),
  parameter int LW     = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic          one_line,
  input  logic          tick,
  output logic [PW-1:0] pos,
  output logic          last_tick
);
  localparam logic [PW-1:0] POS_LAST  = PW'(PERIOD - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

  logic [LW-1:0] line_q;
  logic [LW-1:0] limit;
  logic          period_end;

  always_comb begin
    limit      = one_line ? '0 : LINE_LAST;
    period_end = run && tick && (pos == POS_LAST);
    last_tick  = period_end && (line_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos    <= '0;
      line_q <= '0;
    end else if (run && tick) begin
      if (period_end) begin
        pos    <= '0;
        line_q <= last_tick ? '0 : line_q + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ftx_ctrl.sv
// Run-mode state: accepts strobes only when idle, frame strobe has priority.
module ftx_ctrl
  import ftx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_frame,
  input  logic      start_line,
  input  logic      last_tick,
  output ftx_mode_e mode,
  output logic      clear,
  output logic      done
);
  always_comb clear = (mode == MODE_IDLE) && (start_frame || start_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_IDLE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (mode)
        MODE_IDLE: begin
          if (start_frame)     mode <= MODE_FRAME;
          else if (start_line) mode <= MODE_LINE;
        end
        default: begin
          if (last_tick) begin
            mode <= MODE_IDLE;
            done <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ftx_vshift_seq.sv
module ftx_vshift_seq
  import ftx_pkg::*;
#(
  parameter int PERIOD      = 48,
  parameter int HIGH        = 30,
  parameter int PHASES      = 4,
  parameter int FRAME_LINES = 1048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start_frame,
  input  logic              start_line,
  output logic [PHASES-1:0] img_ph,
  output logic [PHASES-1:0] stor_ph,
  output logic              busy,
  output logic              done
);
  localparam int PW = $clog2(PERIOD);

  ftx_mode_e         mode;
  logic              clear;
  logic              last_tick;
  logic [PW-1:0]     pos_q;
  logic [PHASES-1:0] wave;
  logic [PHASES-1:0] rest;

  ftx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_frame(start_frame), .start_line(start_line),
    .last_tick(last_tick), .mode(mode), .clear(clear), .done(done)
  );

  ftx_tick_counter #(.PERIOD(PERIOD), .LINES(FRAME_LINES), .PW(PW)) u_cnt (
    .clk(clk), .rst(rst), .clear(clear), .run(mode != MODE_IDLE),
    .one_line(mode == MODE_LINE), .tick(tick), .pos(pos_q), .last_tick(last_tick)
  );

  ftx_phase_gen #(.PERIOD(PERIOD), .HIGH(HIGH), .PHASES(PHASES), .PW(PW)) u_wave (
    .pos(pos_q), .lvl(wave)
  );

  ftx_phase_gen #(.PERIOD(PERIOD), .HIGH(HIGH), .PHASES(PHASES), .PW(PW)) u_rest (
    .pos('0), .lvl(rest)
  );

  always_comb busy = (mode != MODE_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      img_ph  <= rest;
      stor_ph <= rest;
    end else begin
      unique case (mode)
        MODE_FRAME: begin
          img_ph  <= wave;
          stor_ph <= wave;
        end
        MODE_LINE: begin
          img_ph  <= rest;
          stor_ph <= wave;
        end
        default: begin
          img_ph  <= rest;
          stor_ph <= rest;
        end
      endcase
    end
  end
endmodule

// File: rtl/ftx_vshift_chk.sv
module ftx_vshift_chk #(
  parameter int PERIOD = 48,
  parameter int HIGH   = 30,
  parameter int PHASES = 4,
  parameter int PW     = $clog2(PERIOD)
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              busy,
  input logic              done,
  input logic [PHASES-1:0] img_ph,
  input logic [PHASES-1:0] stor_ph,
  input logic [PW-1:0]     pos
);
  function automatic logic [PHASES-1:0] rest_level();
    logic [PHASES-1:0] r;
    for (int k = 0; k < PHASES; k++)
      r[k] = (((PERIOD - k * (PERIOD / PHASES)) % PERIOD) < HIGH);
    return r;
  endfunction

  localparam logic [PHASES-1:0] REST = rest_level();

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_groups_lockstep_R3: assert property (@(posedge clk) disable iff (rst)
    (img_ph != REST) |-> (img_ph == stor_ph));
  assert_rest_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (img_ph == REST && stor_ph == REST));
  assert_no_step_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !done) |=> $stable(pos));
  assert_overlap_never_all_low_R2: assert property (@(posedge clk) disable iff (rst)
    stor_ph != '0);
endmodule

bind ftx_vshift_seq ftx_vshift_chk #(
  .PERIOD(PERIOD), .HIGH(HIGH), .PHASES(PHASES), .PW($clog2(PERIOD))
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .busy(busy), .done(done),
  .img_ph(img_ph), .stor_ph(stor_ph), .pos(pos_q)
);

// File: tb/sim_ftx_vshift_seq.sv
`timescale 1ns/1ps
module sim_ftx_vshift_seq;
  localparam int LINES = 3;
  localparam logic [3:0] REST = 4'b1101;

  logic clk = 1'b0;
  logic rst, tick, start_frame, start_line;
  logic [3:0] img_ph, stor_ph;
  logic busy, done;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ftx_vshift_seq #(.FRAME_LINES(LINES)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .start_frame(start_frame),
    .start_line(start_line), .img_ph(img_ph), .stor_ph(stor_ph),
    .busy(busy), .done(done)
  );

  function automatic logic [3:0] ref_wave(int p);
    logic [3:0] w;
    for (int k = 0; k < 4; k++) w[k] = (((p - 12 * k) % 48 + 48) % 48) < 30;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Pulses a strobe pair through one edge; ends at the following negedge.
  task automatic strobe(bit sf, bit sl);
    start_frame = sf; start_line = sl; tick = 1'b1;
    @(posedge clk); @(negedge clk);
    start_frame = 1'b0; start_line = 1'b0;
  endtask

  // Follows an accepted run until done. poke_at: cycle in which a stray strobe is raised.
  task automatic follow(bit frame_mode, int total, int tick_every, int poke_at, bit poke_frame);
    int cnt = 0;
    int cyc = 0;
    while (cnt < total && cyc < 20000) begin
      bit tk = (cyc % tick_every) == 0;
      bit exp_done;
      tick = tk;
      if (cyc == poke_at) begin
        if (poke_frame) start_frame = 1'b1; else start_line = 1'b1;
      end
      @(posedge clk); @(negedge clk);
      start_frame = 1'b0; start_line = 1'b0;
      exp_done = tk && (cnt == total - 1);
      chk("R1 R2 stor_ph", stor_ph, ref_wave(cnt % 48));
      if (frame_mode) chk("R3 img_ph", img_ph, ref_wave(cnt % 48));
      else            chk("R4 img_ph rest", img_ph, REST);
      chk("R7 done", done, exp_done);
      chk("R7 R8 busy", busy, !exp_done);
      if (tk) cnt++;
      cyc++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; tick = 1'b0; start_frame = 1'b0; start_line = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R5 reset img", img_ph, REST);
    chk("R5 reset stor", stor_ph, REST);
    chk("R5 reset busy", busy, 1'b0);
    chk("R7 reset done", done, 1'b0);
  endtask

  task automatic t_idle_hold();
    tick = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R5 idle img", img_ph, REST);
    chk("R5 idle stor", stor_ph, REST);
    chk("R7 idle done", done, 1'b0);
  endtask

  // Frame shift, every cycle a tick, stray line strobe mid-run (R8).
  task automatic t_frame();
    strobe(1'b1, 1'b0);
    chk("R3 busy after start", busy, 1'b1);
    chk("R5 first cycle rest", stor_ph, REST);
    follow(1'b1, LINES * 48, 1, 70, 1'b0);
    @(negedge clk);
    chk("R7 done drops", done, 1'b0);
    chk("R5 rest after frame", img_ph, REST);
  endtask

  // Line transfer on sparse ticks, stray frame strobe mid-run (R4 R6 R8).
  task automatic t_line_sparse();
    strobe(1'b0, 1'b1);
    chk("R4 busy after start", busy, 1'b1);
    follow(1'b0, 48, 3, 20, 1'b1);
    @(negedge clk);
    chk("R6 R5 rest after line", stor_ph, REST);
    chk("R8 stays idle", busy, 1'b0);
  endtask

  // Both strobes at once: frame wins (R9).
  task automatic t_both();
    strobe(1'b1, 1'b1);
    follow(1'b1, LINES * 48, 2, -1, 1'b0);
  endtask

  // Strobe raised in the done cycle is accepted at once (R7).
  task automatic t_start_on_done();
    strobe(1'b0, 1'b1);
    follow(1'b0, 48, 1, -1, 1'b0);
    chk("R7 done before back-to-back", done, 1'b1);
    strobe(1'b0, 1'b1);
    chk("R7 accepted in done cycle", busy, 1'b1);
    follow(1'b0, 48, 1, -1, 1'b0);
    @(negedge clk);
    chk("R7 idle after second", busy, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_hold();
    t_frame();
    t_line_sparse();
    t_both();
    t_start_on_done();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule